// File: doc/BRIEF.md
# Programmable CRC Accelerator

This block is a CRC accelerator that sits as a single slave on a simple 32-bit register bus with byte enables. Software programs a generator polynomial, a starting remainder and a control word, then streams data into the data register. Each data write is consumed at the width of the access itself. A full word feeds 32 bits, a half word 16 and a single byte 8. All input goes most significant bit first into a non-reflected CRC engine. Reading the data register returns the running remainder.

The engine folds one byte per clock cycle. One write can wait in a one-entry holding slot while the engine still works on the previous one. A further data write, and any other access, is held off by pulling the bus ready low until it can complete. Nothing is dropped. Setting the restart bit of the control word reloads the remainder from the start-value register. The remainder width can be 32, 16, 8 or 7 bits. Two options, input byte bit reversal and output bit reversal, cover reflected algorithms.

Top module: `crc_unit`

## Requirements
- R1: After reset the control word reads 0 (32-bit width, no reversal), the start value reads 0xFFFFFFFF, the polynomial reads 0x04C11DB7 and the data register reads 0xFFFFFFFF.
- R2: The start value is at offset 0x10 and the polynomial at 0x14. With start value 0x1D0F, polynomial 0x1021, control 0x0009 (16-bit width plus restart), the half-word writes (byte enables 0011) 0x0031 then 0x0032 leave 0xEA94 in the data register at offset 0x00.
- R3: The access width sets the bits consumed. Byte enables 1111 feed bits 31..0, 0011 feed bits 15..0, 1100 feed bits 31..16, and a single enabled byte feeds that byte lane. Every case is MSB first. Writing 0x00000031 then 0x00000032 as full words in the R2 setup gives 0x5197.
- R4: A data write with any other byte-enable pattern completes on the bus but leaves the remainder unchanged.
- R5: Control is at offset 0x08. Bit 0 is a restart command that copies the start-value register into the remainder. Bit 0 always reads back as 0.
- R6: Control bits [4:3] pick the width: 00=32, 01=16, 10=8, 11=7 bits. The polynomial and the remainder use only that many low bits, and the data register read has all higher bits zero.
- R7: Control bit 5 set bit-reverses every input byte before it enters the engine.
- R8: Control bit 7 set returns the remainder bit-reversed over the selected width when the data register is read.
- R9: The engine takes one byte per cycle. A read of the data register issued the cycle after a write into an idle engine stalls 4, 2 or 1 cycles for a 32-bit, 16-bit or 8-bit write.
- R10: One data write may wait behind the one being processed. A further data write is stalled by bus_ready low, not dropped, and all written data enters the result.
- R11: With no data write in progress and no restart, the remainder holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_valid | input | 1 | Access request |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte address of the register |
| bus_be | input | 4 | Byte enables of the access |
| bus_wdata | input | 32 | Write data |
| bus_ready | output | 1 | Access completes at this clock edge when high |
| bus_rdata | output | 32 | Read data, valid while bus_ready is high |

## Verification
The checker watches several properties on every cycle. Restart loads the exact start value, and the remainder stays put while the engine is idle. A read that hits a busy engine is stalled, and no access stalls longer than the deepest queue allows. Control bit 0 and, in 16-bit mode, the upper half of a data read stay zero. The CRC values themselves only show up in the bench scenarios. These cover the lane mapping of each byte-enable pattern, every width and reversal combination, and the stall counts after writes of each width. They also cover queued back-to-back writes whose data must all reach the result.

// File: rtl/crc_unit_pkg.sv
package crc_unit_pkg;

    localparam int unsigned BUS_W  = 32;
    localparam int unsigned ADDR_W = 5;
    localparam int unsigned BE_W   = BUS_W / 8;
    localparam int unsigned CNT_W  = $clog2(BE_W + 1);

    localparam logic [ADDR_W-1:0] OFF_DATA = 5'h00;
    localparam logic [ADDR_W-1:0] OFF_CTRL = 5'h08;
    localparam logic [ADDR_W-1:0] OFF_INIT = 5'h10;
    localparam logic [ADDR_W-1:0] OFF_POLY = 5'h14;

    typedef enum logic [1:0] {
        SZ_32 = 2'b00,
        SZ_16 = 2'b01,
        SZ_8  = 2'b10,
        SZ_7  = 2'b11
    } crc_size_e;

    typedef struct packed {
        logic [BUS_W-1:0] word;    // left-justified, next byte in [31:24]
        logic [CNT_W-1:0] nbytes;  // bytes still to fold
    } beat_t;

    function automatic int size_top(crc_size_e s);
        case (s)
            SZ_32:   return 31;
            SZ_16:   return 15;
            SZ_8:    return 7;
            default: return 6;
        endcase
    endfunction

    function automatic logic [BUS_W-1:0] size_mask(crc_size_e s);
        case (s)
            SZ_32:   return 32'hFFFF_FFFF;
            SZ_16:   return 32'h0000_FFFF;
            SZ_8:    return 32'h0000_00FF;
            default: return 32'h0000_007F;
        endcase
    endfunction

    function automatic logic [7:0] flip8(logic [7:0] b);
        logic [7:0] o;
        for (int i = 0; i < 8; i++) o[i] = b[7-i];
        return o;
    endfunction

    function automatic logic [BUS_W-1:0] flip_width(logic [BUS_W-1:0] v, crc_size_e s);
        logic [BUS_W-1:0] o;
        int t;
        o = '0;
        t = size_top(s);
        for (int i = 0; i < BUS_W; i++) begin
            if (i <= t) o[i] = v[t-i];
        end
        return o;
    endfunction

    // one byte, MSB first, non-reflected
    function automatic logic [BUS_W-1:0] crc_byte(logic [BUS_W-1:0] rem, logic [7:0] b,
                                                  logic [BUS_W-1:0] poly, crc_size_e s);
        logic [BUS_W-1:0] r;
        logic [BUS_W-1:0] m;
        logic             fb;
        int               t;
        m = size_mask(s);
        t = size_top(s);
        r = rem & m;
        for (int i = 7; i >= 0; i--) begin
            fb = r[t] ^ b[i];
            r  = (r << 1) & m;
            if (fb) r = r ^ (poly & m);
        end
        return r;
    endfunction

endpackage

// File: rtl/crc_unit_lanes.sv
module crc_unit_lanes
    import crc_unit_pkg::*;
(
    input  logic [BE_W-1:0]  be,
    input  logic [BUS_W-1:0] wdata,
    output beat_t            beat,
    output logic             fmt_ok
);

    always_comb begin
        beat   = '0;
        fmt_ok = 1'b1;
        case (be)
            4'b1111: begin beat.word = wdata;                  beat.nbytes = 3'd4; end
            4'b0011: begin beat.word = {wdata[15:0], 16'h0};   beat.nbytes = 3'd2; end
            4'b1100: begin beat.word = {wdata[31:16], 16'h0};  beat.nbytes = 3'd2; end
            4'b0001: begin beat.word = {wdata[7:0], 24'h0};    beat.nbytes = 3'd1; end
            4'b0010: begin beat.word = {wdata[15:8], 24'h0};   beat.nbytes = 3'd1; end
            4'b0100: begin beat.word = {wdata[23:16], 24'h0};  beat.nbytes = 3'd1; end
            4'b1000: begin beat.word = {wdata[31:24], 24'h0};  beat.nbytes = 3'd1; end
            default: fmt_ok = 1'b0;
        endcase
    end

endmodule

// File: rtl/crc_unit_engine.sv
module crc_unit_engine
    import crc_unit_pkg::*;
#(
    parameter logic [BUS_W-1:0] INIT_RST = 32'hFFFF_FFFF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  beat_t            push_beat,
    input  logic             load_init,
    input  logic [BUS_W-1:0] init_val,
    input  logic [BUS_W-1:0] poly,
    input  crc_size_e        size_sel,
    input  logic             rev_in,
    output logic [BUS_W-1:0] rem,
    output logic             pend_full,
    output logic             busy
);

    typedef struct packed {
        logic             pend_v;
        beat_t            pend;
        beat_t            sh;
        logic [BUS_W-1:0] rem;
    } eng_t;

    eng_t       eng_d, eng_q;
    logic [7:0] byte_in;

    always_comb begin
        eng_d   = eng_q;
        byte_in = rev_in ? flip8(eng_q.sh.word[BUS_W-1 -: 8]) : eng_q.sh.word[BUS_W-1 -: 8];

        if (eng_q.sh.nbytes != '0) begin
            eng_d.rem       = crc_byte(eng_q.rem, byte_in, poly, size_sel);
            eng_d.sh.word   = eng_q.sh.word << 8;
            eng_d.sh.nbytes = eng_q.sh.nbytes - 1'b1;
        end

        if (load_init) eng_d.rem = init_val;

        if (push) begin
            eng_d.pend_v = 1'b1;
            eng_d.pend   = push_beat;
        end

        if (eng_d.sh.nbytes == '0 && eng_d.pend_v) begin
            eng_d.sh     = eng_d.pend;
            eng_d.pend_v = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eng_q.pend_v <= 1'b0;
            eng_q.pend   <= '0;
            eng_q.sh     <= '0;
            eng_q.rem    <= INIT_RST;
        end else begin
            eng_q <= eng_d;
        end
    end

    assign rem       = eng_q.rem;
    assign pend_full = eng_q.pend_v;
    assign busy      = eng_q.pend_v | (eng_q.sh.nbytes != '0);

endmodule

// File: rtl/crc_unit_regs.sv
module crc_unit_regs
    import crc_unit_pkg::*;
#(
    parameter logic [BUS_W-1:0] INIT_RST = 32'hFFFF_FFFF,
    parameter logic [BUS_W-1:0] POLY_RST = 32'h04C1_1DB7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_acc,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BE_W-1:0]   be,
    input  logic [BUS_W-1:0]  wdata,
    input  logic [BUS_W-1:0]  rem,
    output crc_size_e         size_sel,
    output logic              rev_in,
    output logic              rev_out,
    output logic [BUS_W-1:0]  init_q,
    output logic [BUS_W-1:0]  poly_q,
    output logic              load_init,
    output logic [BUS_W-1:0]  rdata
);

    typedef struct packed {
        crc_size_e        size;
        logic             rin;
        logic             rout;
        logic [BUS_W-1:0] init;
        logic [BUS_W-1:0] poly;
    } regs_t;

    regs_t            regs_d, regs_q;
    logic [BUS_W-1:0] shown;

    function automatic logic [BUS_W-1:0] merge(logic [BUS_W-1:0] old, logic [BUS_W-1:0] nw,
                                               logic [BE_W-1:0] en);
        logic [BUS_W-1:0] o;
        o = old;
        for (int k = 0; k < BE_W; k++) begin
            if (en[k]) o[8*k +: 8] = nw[8*k +: 8];
        end
        return o;
    endfunction

    always_comb begin
        regs_d    = regs_q;
        load_init = 1'b0;
        if (wr_acc) begin
            case (addr)
                OFF_CTRL: if (be[0]) begin
                    regs_d.size = crc_size_e'(wdata[4:3]);
                    regs_d.rin  = wdata[5];
                    regs_d.rout = wdata[7];
                    load_init   = wdata[0];
                end
                OFF_INIT: regs_d.init = merge(regs_q.init, wdata, be);
                OFF_POLY: regs_d.poly = merge(regs_q.poly, wdata, be);
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q.size <= SZ_32;
            regs_q.rin  <= 1'b0;
            regs_q.rout <= 1'b0;
            regs_q.init <= INIT_RST;
            regs_q.poly <= POLY_RST;
        end else begin
            regs_q <= regs_d;
        end
    end

    always_comb begin
        shown = regs_q.rout ? flip_width(rem, regs_q.size) : rem;
        case (addr)
            OFF_DATA: rdata = shown & size_mask(regs_q.size);
            OFF_CTRL: rdata = {24'h0, regs_q.rout, 1'b0, regs_q.rin, regs_q.size, 3'b000};
            OFF_INIT: rdata = regs_q.init;
            OFF_POLY: rdata = regs_q.poly;
            default:  rdata = '0;
        endcase
    end

    assign size_sel = regs_q.size;
    assign rev_in   = regs_q.rin;
    assign rev_out  = regs_q.rout;
    assign init_q   = regs_q.init;
    assign poly_q   = regs_q.poly;

endmodule

// File: rtl/crc_unit.sv
module crc_unit
    import crc_unit_pkg::*;
#(
    parameter logic [31:0] INIT_RST = 32'hFFFF_FFFF,
    parameter logic [31:0] POLY_RST = 32'h04C1_1DB7
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_valid,
    input  logic        bus_write,
    input  logic [4:0]  bus_addr,
    input  logic [3:0]  bus_be,
    input  logic [31:0] bus_wdata,
    output logic        bus_ready,
    output logic [31:0] bus_rdata
);

    beat_t            beat;
    logic             fmt_ok;
    logic             is_data;
    logic             push;
    logic             wr_acc;
    logic             load_init;
    logic             pend_full;
    logic             eng_busy;
    logic [BUS_W-1:0] rem_q;
    logic [BUS_W-1:0] init_q;
    logic [BUS_W-1:0] poly_q;
    crc_size_e        size_sel;
    logic             rev_in;
    logic             rev_out;

    assign is_data   = (bus_addr == OFF_DATA);
    assign bus_ready = (is_data && bus_write) ? !pend_full : !eng_busy;
    assign wr_acc    = bus_valid && bus_write && bus_ready;
    assign push      = wr_acc && is_data && fmt_ok;

    crc_unit_lanes i_lanes (
        .be     (bus_be),
        .wdata  (bus_wdata),
        .beat   (beat),
        .fmt_ok (fmt_ok)
    );

    crc_unit_regs #(
        .INIT_RST (INIT_RST),
        .POLY_RST (POLY_RST)
    ) i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_acc    (wr_acc),
        .addr      (bus_addr),
        .be        (bus_be),
        .wdata     (bus_wdata),
        .rem       (rem_q),
        .size_sel  (size_sel),
        .rev_in    (rev_in),
        .rev_out   (rev_out),
        .init_q    (init_q),
        .poly_q    (poly_q),
        .load_init (load_init),
        .rdata     (bus_rdata)
    );

    crc_unit_engine #(
        .INIT_RST (INIT_RST)
    ) i_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_beat (beat),
        .load_init (load_init),
        .init_val  (init_q),
        .poly      (poly_q),
        .size_sel  (size_sel),
        .rev_in    (rev_in),
        .rem       (rem_q),
        .pend_full (pend_full),
        .busy      (eng_busy)
    );

endmodule

// File: rtl/crc_unit_chk.sv
module crc_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        bus_valid,
    input logic        bus_write,
    input logic [4:0]  bus_addr,
    input logic        bus_ready,
    input logic [31:0] bus_rdata,
    input logic        eng_busy,
    input logic        push,
    input logic        load_init,
    input logic [31:0] rem,
    input logic [31:0] init_val,
    input logic [1:0]  size_sel
);

    logic [4:0] stall_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stall_cnt <= '0;
        else if (bus_valid && !bus_ready) stall_cnt <= (stall_cnt == 5'd31) ? stall_cnt : stall_cnt + 1'b1;
        else stall_cnt <= '0;
    end

    assert_restart_reads_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_write && bus_addr == 5'h08 && bus_ready) |-> (bus_rdata[0] == 1'b0));

    assert_restart_loads_R5: assert property (@(posedge clk) disable iff (!rst_n)
        load_init |=> (rem == $past(init_val)));

    assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!eng_busy && !push && !load_init) |=> $stable(rem));

    assert_width_mask_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_write && bus_addr == 5'h00 && bus_ready && size_sel == 2'b01)
            |-> (bus_rdata[31:16] == 16'h0));

    assert_busy_read_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_write && eng_busy) |-> !bus_ready);

    assert_no_endless_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
        stall_cnt <= 5'd12);

endmodule

bind crc_unit crc_unit_chk i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .bus_ready (bus_ready),
    .bus_rdata (bus_rdata),
    .eng_busy  (eng_busy),
    .push      (push),
    .load_init (load_init),
    .rem       (rem_q),
    .init_val  (init_q),
    .size_sel  (size_sel)
);

// File: tb/test_crc_unit.sv
`timescale 1ns/1ps
module test_crc_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [3:0]  bus_be = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_ready;
    logic [31:0] bus_rdata;

    int unsigned total = 0;
    int unsigned bad = 0;
    int unsigned stalls = 0;
    bit          done = 1'b0;

    logic [31:0] m_rem  = 32'hFFFF_FFFF;
    logic [31:0] m_init = 32'hFFFF_FFFF;
    logic [31:0] m_poly = 32'h04C1_1DB7;
    logic [1:0]  m_size = 2'b00;
    bit          m_rin = 1'b0;
    bit          m_rout = 1'b0;

    crc_unit i_crc_unit (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .bus_be    (bus_be),
        .bus_wdata (bus_wdata),
        .bus_ready (bus_ready),
        .bus_rdata (bus_rdata)
    );

    always #4 clk = ~clk;

    function automatic int m_width();
        case (m_size)
            2'b00:   return 32;
            2'b01:   return 16;
            2'b10:   return 8;
            default: return 7;
        endcase
    endfunction

    function automatic logic [31:0] m_mask();
        int w = m_width();
        return (w == 32) ? 32'hFFFF_FFFF : ((32'h1 << w) - 32'h1);
    endfunction

    function automatic void m_byte(logic [7:0] b_raw);
        logic [7:0]  b;
        logic [31:0] msk = m_mask();
        logic [31:0] r = m_rem & msk;
        int          w = m_width();
        logic        top;
        for (int k = 0; k < 8; k++) b[k] = m_rin ? b_raw[7-k] : b_raw[k];
        for (int k = 7; k >= 0; k--) begin
            top = r[w-1];
            r = (r << 1) & msk;
            if (top != b[k]) r = r ^ (m_poly & msk);
        end
        m_rem = r;
    endfunction

    function automatic void m_data(logic [3:0] be, logic [31:0] d);
        case (be)
            4'b1111: begin m_byte(d[31:24]); m_byte(d[23:16]); m_byte(d[15:8]); m_byte(d[7:0]); end
            4'b0011: begin m_byte(d[15:8]); m_byte(d[7:0]); end
            4'b1100: begin m_byte(d[31:24]); m_byte(d[23:16]); end
            4'b0001: m_byte(d[7:0]);
            4'b0010: m_byte(d[15:8]);
            4'b0100: m_byte(d[23:16]);
            4'b1000: m_byte(d[31:24]);
            default: ;
        endcase
    endfunction

    function automatic void m_ctrl(logic [31:0] d);
        m_size = d[4:3];
        m_rin  = d[5];
        m_rout = d[7];
        if (d[0]) m_rem = m_init;
    endfunction

    function automatic logic [31:0] m_read();
        logic [31:0] msk = m_mask();
        logic [31:0] v = m_rem & msk;
        logic [31:0] o = '0;
        int          w = m_width();
        if (m_rout) begin
            for (int i = 0; i < w; i++) o[i] = v[w-1-i];
            v = o;
        end
        return v & msk;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [4:0] a, input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_be = be; bus_wdata = d;
        stalls = 0;
        #1;
        while (!bus_ready) begin stalls++; @(negedge clk); #1; end
        @(posedge clk); #1;
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic bus_rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a; bus_be = 4'hF;
        stalls = 0;
        #1;
        while (!bus_ready) begin stalls++; @(negedge clk); #1; end
        d = bus_rdata;
        @(posedge clk); #1;
        bus_valid = 1'b0;
    endtask

    task automatic wr_data(input logic [3:0] be, input logic [31:0] d);
        bus_wr(5'h00, be, d);
        m_data(be, d);
    endtask

    task automatic wr_ctrl(input logic [31:0] d);
        bus_wr(5'h08, 4'b0001, d);
        m_ctrl(d);
    endtask

    task automatic check_data(input string tag);
        logic [31:0] v;
        bus_rd(5'h00, v);
        chk(tag, v, m_read());
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [3:0]  be_list [8];
        be_list = '{4'b1111, 4'b0011, 4'b1100, 4'b0001, 4'b0010, 4'b0100, 4'b1000, 4'b0101};
        v = $urandom(32'd2024);

        repeat (4) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset state
        bus_rd(5'h08, v); chk("R1 ctrl", v, 32'h0);
        bus_rd(5'h10, v); chk("R1 init", v, 32'hFFFF_FFFF);
        bus_rd(5'h14, v); chk("R1 poly", v, 32'h04C1_1DB7);
        bus_rd(5'h00, v); chk("R1 data", v, 32'hFFFF_FFFF);

        // R2 half-word stream
        bus_wr(5'h10, 4'hF, 32'h0000_1D0F); m_init = 32'h0000_1D0F;
        bus_wr(5'h14, 4'hF, 32'h0000_1021); m_poly = 32'h0000_1021;
        wr_ctrl(32'h9);
        bus_rd(5'h08, v); chk("R5 restart bit reads zero", v, 32'h8);
        wr_data(4'b0011, 32'h31);
        wr_data(4'b0011, 32'h32);
        bus_rd(5'h00, v); chk("R2 half-word result", v, 32'hEA94);

        // R3 full-word stream of same values
        wr_ctrl(32'h9);
        bus_rd(5'h00, v); chk("R5 restart reload", v, 32'h1D0F);
        wr_data(4'hF, 32'h31);
        wr_data(4'hF, 32'h32);
        bus_rd(5'h00, v); chk("R3 full-word result", v, 32'h5197);

        // R3 lanes, R4 invalid enables
        wr_ctrl(32'h1);
        for (int i = 0; i < 7; i++) begin
            wr_data(be_list[i], $urandom);
            check_data("R3 lane mapping");
        end
        bus_rd(5'h00, v);
        bus_wr(5'h00, 4'b0101, 32'hDEAD_BEEF);
        bus_rd(5'h00, m_rem); chk("R4 odd enables ignored", m_rem, v);
        bus_wr(5'h00, 4'b0000, 32'h1234_5678);
        check_data("R4 empty enables ignored");

        // R9 latency per width
        wr_data(4'hF, 32'hA5A5_0001);
        check_data("R9 data after word"); chk("R9 word stall", stalls, 4);
        wr_data(4'b0011, 32'h0000_7E7E);
        check_data("R9 data after half"); chk("R9 half stall", stalls, 2);
        wr_data(4'b0100, 32'h0042_0000);
        check_data("R9 data after byte"); chk("R9 byte stall", stalls, 1);

        // R10 back-to-back writes
        wr_data(4'hF, 32'h1111_2222);
        wr_data(4'hF, 32'h3333_4444);
        wr_data(4'hF, 32'h5555_6666);
        chk("R10 third write stalled", (stalls > 0) ? 32'h1 : 32'h0, 32'h1);
        check_data("R10 queued data kept");

        // R6 R7 R8 every width and reversal combination
        for (int sz = 0; sz < 4; sz++) begin
            for (int rv = 0; rv < 4; rv++) begin
                bus_wr(5'h14, 4'hF, 32'h04C1_1DB7 ^ (32'h11 * sz)); m_poly = 32'h04C1_1DB7 ^ (32'h11 * sz);
                wr_ctrl({24'h0, rv[1], 1'b0, rv[0], sz[1:0], 3'b001});
                wr_data(4'hF, 32'hC0DE_0000 + sz * 4 + rv);
                wr_data(4'b0010, 32'h0000_9A00);
                if (rv[0]) check_data("R7 input reversal");
                else if (rv[1]) check_data("R8 output reversal");
                else check_data("R6 width select");
            end
        end

        // R11 restart-free idle: other accesses leave result
        bus_wr(5'h10, 4'b0011, 32'h0000_ABCD); m_init = {m_init[31:16], 16'hABCD};
        bus_rd(5'h10, v);
        check_data("R11 remainder held");
        bus_rd(5'h10, v); chk("R11 init byte merge", v, m_init);

        // random mix
        for (int it = 0; it < 150; it++) begin
            logic [31:0] c;
            c = $urandom;
            bus_wr(5'h10, 4'hF, $urandom); bus_rd(5'h10, m_init);
            bus_wr(5'h14, 4'hF, $urandom | 32'h1); bus_rd(5'h14, m_poly);
            wr_ctrl({24'h0, c[7], 1'b0, c[5], c[4:3], 3'b001});
            for (int n = 0; n < 1 + ($urandom % 6); n++) begin
                wr_data(be_list[$urandom % 8], $urandom);
            end
            if (c[5]) check_data("R7 random");
            else if (c[7]) check_data("R8 random");
            else check_data("R6 random");
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule